// File: doc/BRIEF.md
# PMP Access Permission Checker

This block decides whether a memory access may proceed under physical memory protection. A request carries the byte address, the access size in bytes, the set of read, write and execute rights it needs, and the privilege mode of the requester. The checker compares it against a fixed set of protection entries and returns a pass or fail verdict together with the rights that actually apply to that access.

The start address, end address, configuration byte and effective lock flag of each entry come from neighbouring blocks, already decoded. The end address is inclusive. The lock flag already accounts for a locked upper neighbour in top-of-range mode. The checker looks at entries in index order, and the lowest entry that decides the access wins. An access that only partly overlaps an entry is refused at once. Machine mode ignores the rights of entries that are not locked. When nothing matches, or when no entry is switched on, only machine mode gets through.

The verdict is registered. It appears one cycle after the request strobe, with its own valid flag.

Top module: `pmp_checker`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle in which `req_valid` was high. Synchronous reset clears `rsp_valid`, `rsp_allow` and `rsp_perm` to zero.
- R2: An entry's inclusive range [start, end] is tested against two bytes: the first byte `req_addr` and the last byte `req_addr + size - 1`. The sum is truncated to the address width.
- R3: Entries are scanned from index 0 upward. If exactly one of the two bytes lies in an entry's range, the access fails with `rsp_perm` = 000, whatever the higher entries hold. This applies to entries whose mode field is OFF, provided at least one entry is active.
- R4: Configuration byte layout: bit0 R, bit1 W, bit2 X, bits[4:3] address mode, where 00 means OFF. An entry with a mode other than OFF that holds both bytes is a match. An OFF entry that holds both bytes is skipped. The lowest match decides the result.
- R5: Permission encoding on `req_perm` and `rsp_perm` is bit0 R, bit1 W, bit2 X. In a non-machine mode (`req_mode` other than 3), a match gives `rsp_perm` equal to the entry's RWX bits. `rsp_allow` is 1 only if every requested bit is present.
- R6: In machine mode (`req_mode` = 3), a match on an unlocked entry gives `rsp_perm` = 111 and allows the access. A match on a locked entry applies the entry's RWX bits as in R5.
- R7: If no entry matches and no partial overlap occurs, machine mode gets allow with 111. Every other mode gets deny with 000.
- R8: When no entry is active (every mode field is OFF), the default result of R7 applies directly. Ranges of OFF entries then cause no partial-overlap failure.
- R9: A size of zero is treated as XLEN/8 bytes, which is 4 for the default XLEN of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | First byte address |
| req_size | input | SIZE_W | Access size in bytes, 0 selects XLEN/8 |
| req_perm | input | 3 | Requested rights (bit0 R, bit1 W, bit2 X) |
| req_mode | input | 2 | Privilege mode, 3 = machine |
| ent_start | input | N_ENT*ADDR_W | Inclusive start address of each entry, entry i at bits [i*ADDR_W +: ADDR_W] |
| ent_end | input | N_ENT*ADDR_W | Inclusive end address of each entry |
| ent_cfg | input | N_ENT*8 | Configuration byte of each entry |
| ent_lock | input | N_ENT | Effective lock flag of each entry |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_perm | output | 3 | Effective rights |

## Verification
The partial-overlap rule and the full-match rule can both fire in the same lookup, on different entries. The bench provokes this with an access that fully sits inside a higher, fully permissive entry while it straddles the end of a lower one. It expects a deny with no rights, which shows that the lower entry's partial hit took priority over the later match. A second collision pairs the no-active-rules shortcut with an OFF entry whose range half-covers the access. Here the expected result is the mode default, not a partial failure.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam int CFG_W     = 8;
  localparam int CFG_R     = 0;
  localparam int CFG_W_BIT = 1;
  localparam int CFG_X     = 2;
  localparam int CFG_A_LO  = 3;
  localparam int CFG_A_HI  = 4;
  localparam logic [1:0] MODE_MACHINE = 2'd3;
  localparam logic [2:0] PERM_ALL     = 3'b111;

  typedef enum logic [1:0] {
    HIT_NONE    = 2'd0,
    HIT_PARTIAL = 2'd1,
    HIT_FULL    = 2'd2
  } hit_kind_e;
endpackage

// File: rtl/pmp_range_cmp.sv
module pmp_range_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] first_byte,
  input  logic [ADDR_W-1:0] last_byte,
  input  logic [ADDR_W-1:0] rng_start,
  input  logic [ADDR_W-1:0] rng_end,
  output logic              first_in,
  output logic              last_in
);
  // inclusive bounds on both sides
  assign first_in = (first_byte >= rng_start) && (first_byte <= rng_end);
  assign last_in  = (last_byte  >= rng_start) && (last_byte  <= rng_end);
endmodule

// File: rtl/pmp_rule_count.sv
module pmp_rule_count #(
  parameter int N_ENT = 16,
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic [N_ENT-1:0] active,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N_ENT; i++) begin
      count = count + CNT_W'(active[i]);
    end
  end
endmodule

// File: rtl/pmp_prio_scan.sv
module pmp_prio_scan
  import pmp_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] first_in,
  input  logic [N_ENT-1:0] last_in,
  input  logic [N_ENT-1:0] active,
  output hit_kind_e        kind,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    logic found;
    found = 1'b0;
    kind  = HIT_NONE;
    idx   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!found) begin
        if (first_in[i] ^ last_in[i]) begin
          found = 1'b1;
          kind  = HIT_PARTIAL;
          idx   = IDX_W'(i);
        end else if (first_in[i] && last_in[i] && active[i]) begin
          found = 1'b1;
          kind  = HIT_FULL;
          idx   = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int XLEN   = 32,
  parameter int SIZE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic [2:0]              req_perm,
  input  logic [1:0]              req_mode,
  input  logic [N_ENT*ADDR_W-1:0] ent_start,
  input  logic [N_ENT*ADDR_W-1:0] ent_end,
  input  logic [N_ENT*CFG_W-1:0]  ent_cfg,
  input  logic [N_ENT-1:0]        ent_lock,
  output logic                    rsp_valid,
  output logic                    rsp_allow,
  output logic [2:0]              rsp_perm
);
  localparam int IDX_W      = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int CNT_W      = $clog2(N_ENT + 1);
  localparam int DFLT_BYTES = XLEN / 8;

  logic [ADDR_W-1:0] eff_size;
  logic [ADDR_W-1:0] first_byte;
  logic [ADDR_W-1:0] last_byte;
  logic [N_ENT-1:0]  first_in;
  logic [N_ENT-1:0]  last_in;
  logic [N_ENT-1:0]  active;
  logic [N_ENT-1:0]  unused_cfg_hi;
  logic [CNT_W-1:0]  rule_cnt;
  hit_kind_e         hit_kind;
  logic [IDX_W-1:0]  hit_idx;
  logic [CFG_W-1:0]  sel_cfg;
  logic              sel_lock;
  logic              is_machine;
  logic              nxt_allow;
  logic [2:0]        nxt_perm;

  assign eff_size   = (req_size == '0) ? ADDR_W'(DFLT_BYTES) : ADDR_W'(req_size);
  assign first_byte = req_addr;
  assign last_byte  = req_addr + eff_size - ADDR_W'(1);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    pmp_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .first_byte (first_byte),
      .last_byte  (last_byte),
      .rng_start  (ent_start[g*ADDR_W +: ADDR_W]),
      .rng_end    (ent_end[g*ADDR_W +: ADDR_W]),
      .first_in   (first_in[g]),
      .last_in    (last_in[g])
    );
    assign active[g] = |ent_cfg[g*CFG_W+CFG_A_LO +: 2];
    assign unused_cfg_hi[g] = ^ent_cfg[g*CFG_W+CFG_A_HI+1 +: CFG_W-CFG_A_HI-1];
  end

  pmp_rule_count #(.N_ENT(N_ENT)) u_count (
    .active (active),
    .count  (rule_cnt)
  );

  pmp_prio_scan #(.N_ENT(N_ENT)) u_scan (
    .first_in (first_in),
    .last_in  (last_in),
    .active   (active),
    .kind     (hit_kind),
    .idx      (hit_idx)
  );

  assign sel_cfg    = ent_cfg[hit_idx*CFG_W +: CFG_W];
  assign sel_lock   = ent_lock[hit_idx];
  assign is_machine = (req_mode == MODE_MACHINE);

  always_comb begin
    nxt_allow = is_machine;
    nxt_perm  = is_machine ? PERM_ALL : 3'b000;
    if (rule_cnt != '0) begin
      unique case (hit_kind)
        HIT_PARTIAL: begin
          nxt_allow = 1'b0;
          nxt_perm  = 3'b000;
        end
        HIT_FULL: begin
          nxt_perm = PERM_ALL;
          if (!is_machine || sel_lock) begin
            nxt_perm = nxt_perm & {sel_cfg[CFG_X], sel_cfg[CFG_W_BIT], sel_cfg[CFG_R]};
          end
          nxt_allow = ((req_perm & nxt_perm) == req_perm);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_perm  <= 3'b000;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_allow <= nxt_allow;
        rsp_perm  <= nxt_perm;
      end
    end
  end
endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva #(
  parameter int N_ENT = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         req_perm,
  input logic [1:0]         req_mode,
  input logic [N_ENT*8-1:0] ent_cfg,
  input logic               rsp_valid,
  input logic               rsp_allow,
  input logic [2:0]         rsp_perm
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_cfg[i*8+3 +: 2] != 2'b00) all_off = 1'b0;
    end
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_grant_subset_r5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_allow || ((rsp_perm & $past(req_perm)) == $past(req_perm))));
  p_empty_mach_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd3 && all_off) |=> (rsp_allow && rsp_perm == 3'b111));
  p_empty_user_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode != 2'd3 && all_off) |=> (!rsp_allow && rsp_perm == 3'b000));
endmodule

bind pmp_checker pmp_checker_sva #(.N_ENT(N_ENT)) i_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_perm  (req_perm),
  .req_mode  (req_mode),
  .ent_cfg   (ent_cfg),
  .rsp_valid (rsp_valid),
  .rsp_allow (rsp_allow),
  .rsp_perm  (rsp_perm)
);

// File: tb/test_pmp_checker.sv
module test_pmp_checker;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENT  = 16;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 8;
  localparam int NV     = 14;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    req_valid = 1'b0;
  logic [ADDR_W-1:0]       req_addr = '0;
  logic [SIZE_W-1:0]       req_size = '0;
  logic [2:0]              req_perm = '0;
  logic [1:0]              req_mode = '0;
  logic [N_ENT*ADDR_W-1:0] ent_start = '0;
  logic [N_ENT*ADDR_W-1:0] ent_end = '0;
  logic [N_ENT*8-1:0]      ent_cfg = '0;
  logic [N_ENT-1:0]        ent_lock = '0;
  logic                    rsp_valid;
  logic                    rsp_allow;
  logic [2:0]              rsp_perm;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_checker #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .XLEN(32), .SIZE_W(SIZE_W)) i_pmp_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_perm(req_perm), .req_mode(req_mode),
    .ent_start(ent_start), .ent_end(ent_end), .ent_cfg(ent_cfg), .ent_lock(ent_lock),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_perm(rsp_perm)
  );

  // modes: 0 user, 1 supervisor, 3 machine; perm bit0 R, bit1 W, bit2 X
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h1800, 32'h1800, 32'h1800, 32'h4000, 32'h4000, 32'h1FFE, 32'h1FFC,
    32'h1FFD, 32'h5000, 32'h8000, 32'h8000, 32'h1FFC, 32'h1FFD, 32'h0000};
  localparam logic [7:0] V_SIZE [NV] = '{
    8'd4, 8'd4, 8'd4, 8'd4, 8'd8, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd0, 8'd0, 8'd4};
  localparam logic [2:0] V_PERM [NV] = '{
    3'b001, 3'b010, 3'b010, 3'b100, 3'b011, 3'b001, 3'b001,
    3'b001, 3'b100, 3'b001, 3'b001, 3'b001, 3'b001, 3'b001};
  localparam logic [1:0] V_MODE [NV] = '{
    2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd3};
  localparam logic V_ALLOW [NV] = '{
    1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [2:0] V_EPERM [NV] = '{
    3'b001, 3'b001, 3'b111, 3'b011, 3'b011, 3'b000, 3'b001,
    3'b000, 3'b100, 3'b111, 3'b000, 3'b001, 3'b000, 3'b000};
  localparam logic [15:0] V_REQ [NV] = '{
    "R4", "R5", "R6", "R6", "R5", "R3", "R2", "R2", "R4", "R7", "R7", "R9", "R9", "R3"};

  task automatic set_entry(input int i, input logic [31:0] s, input logic [31:0] e,
                           input logic [7:0] cfg, input logic lk);
    ent_start[i*ADDR_W +: ADDR_W] = s;
    ent_end[i*ADDR_W +: ADDR_W]   = e;
    ent_cfg[i*8 +: 8]             = cfg;
    ent_lock[i]                   = lk;
  endtask

  task automatic check(input logic [15:0] tag, input int id, input logic a,
                       input logic [2:0] p, input logic ea, input logic [2:0] ep);
    n_checks++;
    if (a !== ea || p !== ep) begin
      n_fails++;
      $display("FAIL %s case %0d: allow=%0b perm=%03b expected allow=%0b perm=%03b",
               tag, id, a, p, ea, ep);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [7:0] sz,
                        input logic [2:0] pm, input logic [1:0] md);
    @(negedge clk);
    req_addr = a; req_size = sz; req_perm = pm; req_mode = md; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 100, rsp_allow, rsp_perm, 1'b0, 3'b000);
    check("R1", 101, rsp_valid, 3'b000, 1'b0, 3'b000);
    rst = 1'b0;

    // R8: all entries OFF, entry 0 range [0,0] half-covers addr 0..3
    access(32'h0, 8'd4, 3'b111, 2'd3);
    check("R8", 200, rsp_allow, rsp_perm, 1'b1, 3'b111);
    check("R1", 201, rsp_valid, 3'b000, 1'b1, 3'b000);
    access(32'h0, 8'd4, 3'b001, 2'd0);
    check("R8", 202, rsp_allow, rsp_perm, 1'b0, 3'b000);
    @(negedge clk);
    check("R1", 203, rsp_valid, 3'b000, 1'b0, 3'b000);

    // active configuration; cfg bits[4:3]=01 turns entry on
    set_entry(0, 32'h1000, 32'h1FFF, 8'h09, 1'b0);
    set_entry(1, 32'h1800, 32'h2FFF, 8'h0F, 1'b0);
    set_entry(2, 32'h4000, 32'h4FFF, 8'h0B, 1'b1);
    set_entry(3, 32'h5000, 32'h5FFF, 8'h07, 1'b0);
    set_entry(4, 32'h5000, 32'h5FFF, 8'h0C, 1'b0);

    for (int v = 0; v < NV; v++) begin
      access(V_ADDR[v], V_SIZE[v], V_PERM[v], V_MODE[v]);
      check(V_REQ[v], v, rsp_allow, rsp_perm, V_ALLOW[v], V_EPERM[v]);
    end

    // R6: lock on entry 0 makes machine mode honour its read-only bits
    set_entry(0, 32'h1000, 32'h1FFF, 8'h09, 1'b1);
    access(32'h1800, 8'd4, 3'b010, 2'd3);
    check("R6", 300, rsp_allow, rsp_perm, 1'b0, 3'b001);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule